// File: doc/BRIEF.md
# Pulse Width Count Timer

This block is an 8-bit down-counting timer with two modes and a single interrupt request. In interval mode the counter starts from a programmed reload value and counts down on one of several divided internal ticks. Each time the count steps from 1 to what would be 0, the counter raises an underflow flag, reloads and keeps running. In pulse-width mode the counter waits for the opening edge of a pulse on an external pin. It then loads the reload value and counts down while the pulse lasts. On the closing edge it stores the count in a capture buffer and raises a measurement-complete flag and a buffer-full flag.

Software uses a small register port. It starts and stops the counter, sets the interrupt enable, clears flags by writing zero, picks the mode, the closing edge and the tick rate, writes the reload value and reads the capture buffer. Reading the buffer clears the buffer-full flag. All three flags share one interrupt line that the enable gates. A flag whose event lands on the same clock edge as a stop command is not raised. Setting the enable while a flag is already pending raises the request at once.

Top module: `pulse_timer`

## Requirements
- R1: After synchronous reset, irq is low and every register reads zero: control (address 0), configuration (address 1), capture buffer (address 2) and reload (address 3).
- R2: Control bit 0 (run) and bit 1 (interrupt enable) are written at address 0. In interval mode (configuration bit 0 = 0), the write that sets run loads the reload value. With the divide-by-one tick, underflow flag control bit 2 is set on the R-th edge after that write (R = reload). The counter then reloads, so the flag recurs every R ticks.
- R3: Configuration bits 3:2 hold a tick select s. The counter steps once every 2^s clock cycles, so consecutive underflows are R·2^s cycles apart.
- R4: Writing 0 to control bit 2 or bit 3 clears the underflow or measurement-complete flag. Writing 1 leaves it unchanged. Buffer-full (bit 4) is read-only.
- R5: If a control write clears run on the same edge as an underflow, the underflow flag stays clear.
- R6: In pulse-width mode (configuration bit 0 = 1), bit 1 picks the closing edge: 0 measures a high pulse (closes on falling), 1 measures a low pulse (closes on rising). The pin passes a two-flop synchronizer. The opening edge loads the reload value, and every later tick up to and including the closing edge steps the count. At the closing edge the stepped count goes to the buffer and the measurement-complete (bit 3) and buffer-full (bit 4) flags are set. With the divide-by-one tick, a pulse N cycles long captures reload − N.
- R7: In pulse-width mode, a pulse longer than the reload sets the underflow flag. The counter reloads at each underflow and keeps measuring.
- R8: If a control write clears run on the same edge as the closing edge, the measurement-complete and buffer-full flags stay clear and the buffer keeps its old value.
- R9: A read of address 2 returns the capture buffer and clears buffer-full. The measurement-complete flag is unaffected.
- R10: irq is high exactly when the interrupt enable is 1 and at least one of the three flags is set. Setting the enable while a flag is pending raises irq right after that write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, valid one cycle after rd_en |
| rd_valid | output | 1 | High for the cycle that rd_data holds a read result |
| pulse_in | input | 1 | Asynchronous pulse pin to measure |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench lands stop commands on the exact edge of an underflow and of a closing edge. A design that gates its flags with the old run bit instead of the incoming one would raise UF, IR or BF there and fail the control read-back. It measures the spacing between two underflows under a divided tick and the captured value for high and low pulses, including one that wraps through underflow. An off-by-one in the synchronizer or the capture step shows up as a wrong buffer value. It also flips the interrupt enable while flags are pending and checks that a buffer read clears only buffer-full. A registered request or a read that wiped IR would show the wrong irq level.

// File: rtl/pulse_timer_pkg.sv
package pulse_timer_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;

    // register addresses
    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CFG  = 2'd1;
    localparam logic [ADDR_W-1:0] ADR_BUF  = 2'd2;
    localparam logic [ADDR_W-1:0] ADR_RLD  = 2'd3;

    // control register bit positions
    localparam int CB_RUN = 0;
    localparam int CB_IE  = 1;
    localparam int CB_UF  = 2;
    localparam int CB_IR  = 3;
    localparam int CB_BF  = 4;

    // configuration register bit positions
    localparam int CF_MODE   = 0;
    localparam int CF_EDGE   = 1;
    localparam int CF_SEL_LO = 2;

    typedef enum logic {
        MODE_INTERVAL = 1'b0,
        MODE_PULSE    = 1'b1
    } mode_e;

    typedef enum logic {
        CLOSE_FALL = 1'b0,
        CLOSE_RISE = 1'b1
    } close_edge_e;

    typedef struct packed {
        logic bf;
        logic ir;
        logic uf;
    } flags_t;

    function automatic logic [REG_W-1:0] pack_ctrl(logic run, logic ie, flags_t f);
        logic [REG_W-1:0] v;
        v          = '0;
        v[CB_RUN]  = run;
        v[CB_IE]   = ie;
        v[CB_UF]   = f.uf;
        v[CB_IR]   = f.ir;
        v[CB_BF]   = f.bf;
        return v;
    endfunction

endpackage

// File: rtl/pt_tick_gen.sv
module pt_tick_gen #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    // bit i of the prescaler takes part when i < sel
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
        assign mask[i] = (int'(sel) > i);
    end

    assign tick = &(pre_q | ~mask);

endmodule

// File: rtl/pt_pin_sync.sv
module pt_pin_sync
    import pulse_timer_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_in,
    input  close_edge_e close_sel,
    output logic        open_evt,
    output logic        close_evt
);
    localparam int SH_W = SYNC_N + 1;

    logic [SH_W-1:0] sh_q;
    logic            rise;
    logic            fall;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[SH_W-2:0], pin_in};
    end

    always_comb begin
        rise = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
        fall = ~sh_q[SYNC_N-1] & sh_q[SYNC_N];
        if (close_sel == CLOSE_FALL) begin
            open_evt  = rise;
            close_evt = fall;
        end else begin
            open_evt  = fall;
            close_evt = rise;
        end
    end

endmodule

// File: rtl/pt_counter.sv
module pt_counter
    import pulse_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             start,
    input  mode_e            mode,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    input  logic             open_evt,
    input  logic             close_evt,
    output logic             uf_evt,
    output logic             close_hit,
    output logic [CNT_W-1:0] cap_val
);
    logic [CNT_W-1:0] cnt_q;
    logic             meas_q;
    logic             at_one;
    logic [CNT_W-1:0] stepped;
    logic             run_int;
    logic             run_pw;
    logic             counting;
    logic             pw_open;

    always_comb begin
        at_one    = (cnt_q == CNT_W'(1));
        stepped   = at_one ? reload : cnt_q - 1'b1;
        run_int   = run && (mode == MODE_INTERVAL);
        run_pw    = run && (mode == MODE_PULSE) && meas_q;
        pw_open   = run && (mode == MODE_PULSE) && !meas_q && open_evt;
        counting  = run_int || run_pw;
        uf_evt    = counting && tick && at_one;
        close_hit = run_pw && close_evt;
        cap_val   = tick ? stepped : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            meas_q <= 1'b0;
        end else begin
            if (start && mode == MODE_INTERVAL) cnt_q <= reload;
            else if (pw_open)                   cnt_q <= reload;
            else if (counting && tick)          cnt_q <= stepped;

            if (!run || mode != MODE_PULSE) meas_q <= 1'b0;
            else if (pw_open)               meas_q <= 1'b1;
            else if (close_hit)             meas_q <= 1'b0;
        end
    end

    // R2
    load_val_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mode == MODE_INTERVAL) |=> (cnt_q == $past(reload)));

    // R2
    wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (run_int && !start && tick && at_one) |=> (cnt_q == $past(reload)));

    // R6
    meas_done_chk: assert property (@(posedge clk) disable iff (rst)
        close_hit |=> !meas_q);

endmodule

// File: rtl/pt_flags.sv
module pt_flags
    import pulse_timer_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ie,
    input  logic   ctrl_wr,
    input  logic   uf_wbit,
    input  logic   ir_wbit,
    input  logic   run_next,
    input  logic   uf_evt,
    input  logic   close_hit,
    input  logic   buf_rd,
    output logic   cap_take,
    output flags_t flags_q,
    output logic   irq
);
    logic   uf_set;
    flags_t flags_d;

    always_comb begin
        uf_set     = uf_evt && run_next;
        cap_take   = close_hit && run_next;
        flags_d.uf = uf_set   || (flags_q.uf && !(ctrl_wr && !uf_wbit));
        flags_d.ir = cap_take || (flags_q.ir && !(ctrl_wr && !ir_wbit));
        flags_d.bf = cap_take || (flags_q.bf && !buf_rd);
        irq        = ie && (|flags_q);
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    // R5
    uf_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (uf_evt && !run_next && !flags_q.uf) |=> !flags_q.uf);

    // R8
    ir_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (close_hit && !run_next && !flags_q.ir) |=> !flags_q.ir);

    // R9
    bf_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (buf_rd && !(close_hit && run_next)) |=> !flags_q.bf);

    // R4
    uf_wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !uf_wbit && !uf_evt) |=> !flags_q.uf);

endmodule

// File: rtl/pulse_timer.sv
module pulse_timer
    import pulse_timer_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        rd_en,
    input  logic [1:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    input  logic        pulse_in,
    output logic        irq
);
    logic             run_q;
    logic             ie_q;
    mode_e            mode_q;
    close_edge_e      close_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cap_q;

    logic             ctrl_wr;
    logic             run_next;
    logic             start;
    logic             buf_rd;
    logic             tick;
    logic             open_evt;
    logic             close_evt;
    logic             uf_evt;
    logic             close_hit;
    logic             cap_take;
    logic [CNT_W-1:0] cap_val;
    flags_t           flags;
    logic [REG_W-1:0] rd_mux;

    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == ADR_CTRL);
        run_next = ctrl_wr ? wr_data[CB_RUN] : run_q;
        start    = run_next && !run_q;
        buf_rd   = rd_en && (rd_addr == ADR_BUF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            ie_q     <= 1'b0;
            mode_q   <= MODE_INTERVAL;
            close_q  <= CLOSE_FALL;
            sel_q    <= '0;
            reload_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CTRL: begin
                    run_q <= wr_data[CB_RUN];
                    ie_q  <= wr_data[CB_IE];
                end
                ADR_CFG: begin
                    mode_q  <= mode_e'(wr_data[CF_MODE]);
                    close_q <= close_edge_e'(wr_data[CF_EDGE]);
                    sel_q   <= wr_data[CF_SEL_LO +: SEL_W];
                end
                ADR_RLD: reload_q <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           cap_q <= '0;
        else if (cap_take) cap_q <= cap_val;
    end

    pt_tick_gen #(.SEL_W(SEL_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .sel  (sel_q),
        .tick (tick)
    );

    pt_pin_sync #(.SYNC_N(2)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pulse_in),
        .close_sel (close_q),
        .open_evt  (open_evt),
        .close_evt (close_evt)
    );

    pt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run       (run_q),
        .start     (start),
        .mode      (mode_q),
        .tick      (tick),
        .reload    (reload_q),
        .open_evt  (open_evt),
        .close_evt (close_evt),
        .uf_evt    (uf_evt),
        .close_hit (close_hit),
        .cap_val   (cap_val)
    );

    pt_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .ie        (ie_q),
        .ctrl_wr   (ctrl_wr),
        .uf_wbit   (wr_data[CB_UF]),
        .ir_wbit   (wr_data[CB_IR]),
        .run_next  (run_next),
        .uf_evt    (uf_evt),
        .close_hit (close_hit),
        .buf_rd    (buf_rd),
        .cap_take  (cap_take),
        .flags_q   (flags),
        .irq       (irq)
    );

    always_comb begin
        rd_mux = '0;
        case (rd_addr)
            ADR_CTRL: rd_mux = pack_ctrl(run_q, ie_q, flags);
            ADR_CFG: begin
                rd_mux[CF_MODE]             = mode_q;
                rd_mux[CF_EDGE]             = close_q;
                rd_mux[CF_SEL_LO +: SEL_W]  = sel_q;
            end
            ADR_BUF: rd_mux = REG_W'(cap_q);
            default: rd_mux = REG_W'(reload_q);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_mux;
        end
    end

    // R10
    ie_pending_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_data[CB_IE] && !ie_q && flags.bf && !buf_rd) |=> irq);

endmodule

// File: tb/pulse_timer_tb.sv
`timescale 1ns/1ps
module pulse_timer_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       pulse_in = 1'b0;
    logic       irq;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] mon_e;
    string      mon_t;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pulse_timer u_dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .pulse_in (pulse_in),
        .irq      (irq)
    );

    // monitor: pops expected read data as results appear
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            checks = checks + 1;
            if (exp_q.size() == 0) begin
                failures = failures + 1;
                $display("FAIL R1: unexpected read result actual=%02h expected=none", rd_data);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                if (rd_data !== mon_e) begin
                    failures = failures + 1;
                    $display("FAIL %s: read data actual=%02h expected=%02h", mon_t, rd_data, mon_e);
                end
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks = checks + 1;
        if (irq !== e) begin
            failures = failures + 1;
            $display("FAIL %s: irq actual=%0b expected=%0b", t, irq, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(output int t, output bit ok);
        ok = 1'b0;
        t  = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (irq) begin
                ok = 1'b1;
                t  = cyc;
                break;
            end
        end
    endtask

    task automatic pulse(input logic lvl, input int h);
        pulse_in = lvl;
        repeat (h) @(negedge clk);
        pulse_in = ~lvl;
    endtask

    initial begin
        int  t1, t2;
        bit  ok1, ok2;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_irq(1'b0, "R1");
        rd(2'd0, 8'h00, "R1");
        rd(2'd1, 8'h00, "R1");
        rd(2'd2, 8'h00, "R1");
        rd(2'd3, 8'h00, "R1");

        // R2 interval mode, reload 5, divide by one
        wr(2'd3, 8'd5);
        wr(2'd0, 8'h03);
        idle(4);
        chk_irq(1'b0, "R2");
        idle(1);
        chk_irq(1'b1, "R2");
        rd(2'd0, 8'h07, "R2");
        wr(2'd0, 8'h03);          // R4 write 0 clears UF
        chk_irq(1'b0, "R4");
        idle(2);
        chk_irq(1'b0, "R2");
        idle(1);
        chk_irq(1'b1, "R2");      // periodic reload
        wr(2'd0, 8'h07);          // R4 write 1 keeps UF
        chk_irq(1'b1, "R4");
        wr(2'd0, 8'h00);
        rd(2'd0, 8'h00, "R4");

        // R5 stop on the underflow edge
        wr(2'd0, 8'h01);
        idle(4);
        wr(2'd0, 8'h0C);
        rd(2'd0, 8'h00, "R5");

        // R10 enable with UF pending
        wr(2'd0, 8'h01);
        idle(5);
        wr(2'd0, 8'h04);
        chk_irq(1'b0, "R10");
        wr(2'd0, 8'h06);
        chk_irq(1'b1, "R10");
        rd(2'd0, 8'h06, "R10");
        wr(2'd0, 8'h00);
        chk_irq(1'b0, "R4");

        // R3 tick select 2, reload 3: underflows 12 cycles apart
        wr(2'd1, 8'h08);
        wr(2'd3, 8'd3);
        wr(2'd0, 8'h03);
        wait_irq(t1, ok1);
        wr(2'd0, 8'h03);
        wait_irq(t2, ok2);
        checks = checks + 1;
        if (!ok1 || !ok2 || (t2 - t1) != 12) begin
            failures = failures + 1;
            $display("FAIL R3: underflow spacing actual=%0d expected=12", t2 - t1);
        end
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);

        // R6 high pulse of 10 cycles, reload 200
        wr(2'd1, 8'h01);
        wr(2'd3, 8'd200);
        wr(2'd0, 8'h01);
        idle(2);
        pulse(1'b1, 10);
        idle(6);
        rd(2'd0, 8'h19, "R6");
        rd(2'd2, 8'd190, "R9");
        rd(2'd0, 8'h09, "R9");
        wr(2'd0, 8'h01);
        rd(2'd0, 8'h01, "R4");

        // R7 long pulse wraps through underflow, reload 4
        wr(2'd3, 8'd4);
        pulse(1'b1, 10);
        idle(6);
        rd(2'd0, 8'h1D, "R7");
        rd(2'd2, 8'd2, "R7");
        wr(2'd0, 8'h01);
        rd(2'd0, 8'h01, "R4");

        // R6 low pulse of 7 cycles, closes on rising, reload 50
        wr(2'd1, 8'h03);
        pulse_in = 1'b1;
        idle(4);
        wr(2'd3, 8'd50);
        pulse(1'b0, 7);
        idle(6);
        rd(2'd0, 8'h19, "R6");
        rd(2'd2, 8'd43, "R6");
        wr(2'd0, 8'h01);

        // R8 stop on the closing edge
        wr(2'd1, 8'h01);
        pulse_in = 1'b0;
        idle(4);
        wr(2'd3, 8'd100);
        pulse(1'b1, 6);
        idle(2);
        wr(2'd0, 8'h0C);
        rd(2'd0, 8'h00, "R8");
        rd(2'd2, 8'd43, "R8");

        // R10 / R9 enable with IR and BF pending, buffer read keeps IR
        wr(2'd0, 8'h01);
        pulse(1'b1, 5);
        idle(6);
        chk_irq(1'b0, "R10");
        wr(2'd0, 8'h0B);
        chk_irq(1'b1, "R10");
        rd(2'd2, 8'd95, "R9");
        chk_irq(1'b1, "R10");
        wr(2'd0, 8'h03);
        chk_irq(1'b0, "R4");

        idle(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks   = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule